// File: doc/BRIEF.md
# Processor Status Register Unit

This block holds the 16-bit status word of a small CPU core. It has three fields: an interrupt level mask, a register bank pointer and a condition code byte. The condition code byte carries seven flags: interrupt enable (I), stack select (S), sticky (T), negative (N), zero (Z), overflow (V) and carry (C). The core can replace the whole word through a write port. The ALU updates the arithmetic flags one at a time through separate write enables. An interrupt-entry strobe forces the stack select flag high.

Two outputs come from the stored word. The first is a stack-pointer select, which the core uses to choose between the user and system stack pointers. The second is an interrupt gate. It lets a pending interrupt through only when I is set, or when the request is a software interrupt. Decoding instructions, holding the stack pointers and comparing priority levels are all handled elsewhere.

Top module: `psr_unit`

## Requirements
- R1: A synchronous active-high reset gives, on the next clock edge, interrupt level mask 0, bank pointer 0, I = 0 and S = 1. Bits 4 to 0 (T, N, Z, V, C) are undefined until they are first written.
- R2: The word layout is fixed. Bits 15..13 hold the interrupt level mask, bits 12..8 the bank pointer, bit 6 I, bit 5 S, bit 4 T, bit 3 N, bit 2 Z, bit 1 V and bit 0 C. A whole-register write stores wr_data into every field one cycle later.
- R3: Bit 7 of the status word always reads 0. A write of 1 to that bit has no effect.
- R4: The flag port has enables upd_we[4:0], where bit k enables status bit k (4 = T, 2 = Z, 1 = V, 0 = C). An update changes only the enabled flags, one cycle later.
- R5: When upd_we[3] is set, N takes res_sign, the most significant bit of the ALU result.
- R6: When irq_entry is asserted, S becomes 1 on the next edge. Any whole-register write or flag update in that same cycle is discarded, and every other bit keeps its value.
- R7: When a whole-register write and a flag update happen in the same cycle, the write wins.
- R8: sp_sys_sel follows S. A value of 1 selects the system stack pointer and 0 selects the user stack pointer.
- R9: irq_pass = irq_req AND (irq_swi OR I), evaluated on the current status word.
- R10: A flag update never changes the interrupt level mask, the bank pointer, I or S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_entry | input | 1 | Interrupt-entry strobe, forces S |
| wr_en | input | 1 | Whole-register write enable |
| wr_data | input | 16 | Whole-register write data |
| upd_we | input | 5 | Per-flag enables, bit k targets status bit k |
| upd_t | input | 1 | New T value |
| res_sign | input | 1 | ALU result sign bit, new N value |
| upd_z | input | 1 | New Z value |
| upd_v | input | 1 | New V value |
| upd_c | input | 1 | New C value |
| irq_req | input | 1 | Pending interrupt request |
| irq_swi | input | 1 | Request is a software interrupt |
| ps_q | output | 16 | Current status word |
| sp_sys_sel | output | 1 | 1 selects the system stack pointer, 0 the user one |
| irq_pass | output | 1 | Interrupt request allowed through |

## Verification
The bench writes all ones to catch a design that stores bit 7 instead of reading it as zero. It places a write in the same cycle as an interrupt entry and a full flag update: a wrong priority chain would load the written word rather than just setting S. A write collides with a flag update so that a reversed ordering leaves the flags wrong. The gate is exercised with I cleared and the software-interrupt input both low and high, which exposes a gate that ignores the software-interrupt input or inverts I. A flag update with every enable set must leave the upper byte untouched.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int CCR_W   = 8;
  localparam int ARITH_W = 5;
  localparam int BIT_C   = 0;
  localparam int BIT_V   = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_N   = 3;
  localparam int BIT_T   = 4;
  localparam int BIT_S   = 5;
  localparam int BIT_I   = 6;
  localparam int BIT_PAD = 7;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_IRQ   = 2'd1,
    SRC_WRITE = 2'd2,
    SRC_FLAGS = 2'd3
  } psr_src_e;

  function automatic psr_src_e pick_src(input logic irq, input logic wr,
                                        input logic any_upd);
    if (irq)          return SRC_IRQ;
    else if (wr)      return SRC_WRITE;
    else if (any_upd) return SRC_FLAGS;
    else              return SRC_HOLD;
  endfunction
endpackage

// File: rtl/psr_upper.sv
module psr_upper #(
  parameter int ILM_W = 3,
  parameter int RP_W  = 5,
  localparam int UP_W = ILM_W + RP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  psr_pkg::psr_src_e src,
  input  logic [UP_W-1:0] wr_upper,
  output logic [UP_W-1:0] upper_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
    end else if (src == psr_pkg::SRC_WRITE) begin
      upper_q <= wr_upper;
    end
  end
endmodule

// File: rtl/psr_ccr.sv
module psr_ccr
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  psr_src_e           src,
  input  logic [CCR_W-1:0]   wr_ccr,
  input  logic [ARITH_W-1:0] upd_we,
  input  logic [ARITH_W-1:0] upd_val,
  output logic [CCR_W-1:0]   ccr_q
);
  logic i_q;
  logic s_q;
  logic [ARITH_W-1:0] arith_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_q <= 1'b0;
      s_q <= 1'b1;
    end else begin
      case (src)
        SRC_IRQ:   s_q <= 1'b1;
        SRC_WRITE: begin
          i_q <= wr_ccr[BIT_I];
          s_q <= wr_ccr[BIT_S];
        end
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < ARITH_W; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (src == SRC_WRITE) begin
        arith_q[k] <= wr_ccr[k];
      end else if (src == SRC_FLAGS && upd_we[k]) begin
        arith_q[k] <= upd_val[k];
      end
    end
  end

  always_comb begin
    ccr_q          = '0;
    ccr_q[BIT_I]   = i_q;
    ccr_q[BIT_S]   = s_q;
    ccr_q[ARITH_W-1:0] = arith_q;
    ccr_q[BIT_PAD] = 1'b0;
  end
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate (
  input  logic i_flag,
  input  logic irq_req,
  input  logic irq_swi,
  output logic irq_pass
);
  always_comb begin
    irq_pass = irq_req & (irq_swi | i_flag);
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int ILM_W = 3,
  parameter int RP_W  = 5,
  localparam int UP_W = ILM_W + RP_W,
  localparam int PS_W = UP_W + CCR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_entry,
  input  logic            wr_en,
  input  logic [PS_W-1:0] wr_data,
  input  logic [4:0]      upd_we,
  input  logic            upd_t,
  input  logic            res_sign,
  input  logic            upd_z,
  input  logic            upd_v,
  input  logic            upd_c,
  input  logic            irq_req,
  input  logic            irq_swi,
  output logic [PS_W-1:0] ps_q,
  output logic            sp_sys_sel,
  output logic            irq_pass
);
  psr_src_e           src;
  logic [ARITH_W-1:0] upd_val;
  logic [UP_W-1:0]    upper_q;
  logic [CCR_W-1:0]   ccr_q;

  always_comb begin
    upd_val        = '0;
    upd_val[BIT_T] = upd_t;
    upd_val[BIT_N] = res_sign;
    upd_val[BIT_Z] = upd_z;
    upd_val[BIT_V] = upd_v;
    upd_val[BIT_C] = upd_c;
    src            = pick_src(irq_entry, wr_en, |upd_we);
  end

  psr_upper #(.ILM_W(ILM_W), .RP_W(RP_W)) u_upper (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .wr_upper (wr_data[PS_W-1:CCR_W]),
    .upper_q  (upper_q)
  );

  psr_ccr u_ccr (
    .clk     (clk),
    .rst     (rst),
    .src     (src),
    .wr_ccr  (wr_data[CCR_W-1:0]),
    .upd_we  (upd_we),
    .upd_val (upd_val),
    .ccr_q   (ccr_q)
  );

  psr_irq_gate u_gate (
    .i_flag   (ccr_q[BIT_I]),
    .irq_req  (irq_req),
    .irq_swi  (irq_swi),
    .irq_pass (irq_pass)
  );

  assign ps_q       = {upper_q, ccr_q};
  assign sp_sys_sel = ccr_q[BIT_S];
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_entry,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [4:0]  upd_we,
  input logic        irq_req,
  input logic        irq_swi,
  input logic [15:0] ps_q,
  input logic        sp_sys_sel,
  input logic        irq_pass
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (ps_q[15:8] == 8'h00 && ps_q[6] == 1'b0 && ps_q[5] == 1'b1)); // R1
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !irq_entry) |=> ps_q == {$past(wr_data[15:8]), 1'b0, $past(wr_data[6:0])}); // R2
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ps_q[7] == 1'b0); // R3
  AST_IRQ_SETS_S: assert property (@(posedge clk) disable iff (rst)
    irq_entry |=> ps_q[5]); // R6
  AST_IRQ_KEEPS_REST: assert property (@(posedge clk) disable iff (rst)
    irq_entry |=> {ps_q[15:6], ps_q[4:0]} == $past({ps_q[15:6], ps_q[4:0]})); // R6
  AST_UPD_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|upd_we && !wr_en && !irq_entry) |=> $stable(ps_q[15:5])); // R10
  AST_SP_FOLLOWS_S: assert property (@(posedge clk) disable iff (rst)
    sp_sys_sel == ps_q[5]); // R8
  AST_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_pass == (irq_req && (irq_swi || ps_q[6]))); // R9
endmodule

bind psr_unit psr_unit_chk u_chk (.*);

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_entry = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [4:0]  upd_we = '0;
  logic        upd_t = 1'b0, res_sign = 1'b0, upd_z = 1'b0, upd_v = 1'b0, upd_c = 1'b0;
  logic        irq_req = 1'b0, irq_swi = 1'b0;
  logic [15:0] ps_q;
  logic        sp_sys_sel, irq_pass;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] val;
    logic [15:0] mask;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [15:0] m_ps = '0;
  logic [15:0] m_known = '0;

  always #5 clk = ~clk;

  psr_unit u_dut (
    .clk(clk), .rst(rst), .irq_entry(irq_entry), .wr_en(wr_en), .wr_data(wr_data),
    .upd_we(upd_we), .upd_t(upd_t), .res_sign(res_sign), .upd_z(upd_z),
    .upd_v(upd_v), .upd_c(upd_c), .irq_req(irq_req), .irq_swi(irq_swi),
    .ps_q(ps_q), .sp_sys_sel(sp_sys_sel), .irq_pass(irq_pass)
  );

  // fv order: {T, N, Z, V, C} matching status bits 4..0
  task automatic drive(input string tag, input logic r, input logic irq,
                       input logic w, input logic [15:0] wd,
                       input logic [4:0] we, input logic [4:0] fv,
                       input logic req, input logic swi);
    logic exp_pass;
    @(negedge clk);
    rst = r; irq_entry = irq; wr_en = w; wr_data = wd; upd_we = we;
    upd_t = fv[4]; res_sign = fv[3]; upd_z = fv[2]; upd_v = fv[1]; upd_c = fv[0];
    irq_req = req; irq_swi = swi;
    #1;
    if (m_known[6]) begin
      exp_pass = req & (swi | m_ps[6]);
      n_run++;
      if (irq_pass !== exp_pass) begin
        n_fail++;
        $display("FAIL R9 irq_pass actual=%b expected=%b", irq_pass, exp_pass);
      end
    end
    @(posedge clk);
    #1;
    if (r) begin
      m_ps[15:5] = 11'b0000_0000_001;
      m_known    = 16'hFFE0;
    end else if (irq) begin
      m_ps[5] = 1'b1;
    end else if (w) begin
      m_ps    = {wd[15:8], 1'b0, wd[6:0]};
      m_known = 16'hFFFF;
    end else begin
      for (int k = 0; k < 5; k++) begin
        if (we[k]) begin
          m_ps[k]    = fv[k];
          m_known[k] = 1'b1;
        end
      end
    end
    sb_q.push_back('{val: m_ps, mask: m_known, tag: tag});
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if ((ps_q & e.mask) !== (e.val & e.mask)) begin
        n_fail++;
        $display("FAIL %s ps_q actual=%h expected=%h mask=%h", e.tag, ps_q, e.val, e.mask);
      end
      if (e.mask[5]) begin
        n_run++;
        if (sp_sys_sel !== e.val[5]) begin
          n_fail++;
          $display("FAIL R8 sp_sys_sel actual=%b expected=%b", sp_sys_sel, e.val[5]);
        end
      end
    end
  end

  initial begin
    drive("R1", 1, 0, 0, 16'h0000, 5'h00, 5'h00, 0, 0);
    drive("R1", 1, 0, 0, 16'h0000, 5'h00, 5'h00, 1, 0);
    drive("R3", 0, 0, 1, 16'hFFFF, 5'h00, 5'h00, 0, 0);
    drive("R2", 0, 0, 1, 16'hB4C6, 5'h00, 5'h00, 1, 0);
    drive("R2", 0, 0, 1, 16'h1234, 5'h00, 5'h00, 1, 0);
    drive("R9", 0, 0, 0, 16'h0000, 5'h00, 5'h00, 1, 0);
    drive("R9", 0, 0, 0, 16'h0000, 5'h00, 5'h00, 1, 1);
    drive("R4", 0, 0, 0, 16'h0000, 5'b10101, 5'b00011, 0, 0);
    drive("R5", 0, 0, 0, 16'h0000, 5'b01000, 5'b01000, 0, 0);
    drive("R5", 0, 0, 0, 16'h0000, 5'b01000, 5'b10111, 0, 0);
    drive("R8", 0, 0, 1, 16'h0000, 5'h00, 5'h00, 0, 0);
    drive("R6", 0, 1, 1, 16'hFFFF, 5'h1F, 5'h1F, 1, 0);
    drive("R7", 0, 0, 1, 16'h0F0F, 5'h1F, 5'h00, 0, 0);
    drive("R10", 0, 0, 0, 16'h0000, 5'h1F, 5'h1F, 1, 0);
    drive("R4", 0, 0, 0, 16'h0000, 5'b00010, 5'b00000, 0, 0);
    drive("R1", 1, 0, 1, 16'hFFFF, 5'h1F, 5'h1F, 0, 0);
    drive("R9", 0, 0, 0, 16'h0000, 5'h00, 5'h00, 1, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule